// File: doc/BRIEF.md
# Iterative Integer Multiplier with Hi/Lo Result Registers

This unit multiplies two 32-bit integers, signed or unsigned, using one shift-and-add step per clock. A build-time parameter chooses how results reach the register file. In the Hi/Lo style a multiply instruction leaves no direct result. It fills two private 32-bit registers with the upper and lower halves of the 64-bit product, and two read instructions later copy one half out through the result port. In the direct style the Hi/Lo registers are not visible, and two distinct multiply instructions each return one half of the product on the result port when the operation retires.

A request is presented as a one-cycle `start` pulse together with an opcode, the signedness select and both operands. `busy` reports a multiply in flight. In Hi/Lo mode a read of Hi or Lo that arrives during a multiply is held and answered with the fresh product as soon as it exists. That is the interlock a pipeline relies on.

The controller is a three-state machine. State IDLE waits and takes the transition ACCEPT to STEP on a valid multiply opcode. State STEP runs 32 shift-and-add iterations and takes the transition LAST_STEP to FIXUP after the final one. State FIXUP negates the magnitude product when the signs differed, updates Hi/Lo or the result, and takes the transition RETIRE back to IDLE.

Top module: `mul_unit`

## Requirements
- R1: During and right after reset, `busy` is 0, `result_valid` is 0, `result` is 0, and Hi and Lo both read as 0.
- R2: In Hi/Lo mode (`USE_HILO`=1), opcode 0 with `start` while idle starts a multiply. On completion Hi holds product bits 63:32 and Lo holds bits 31:0. The multiply itself never raises `result_valid`.
- R3: In Hi/Lo mode, opcode 1 (read Hi) or opcode 2 (read Lo) with `start` while idle raises `result_valid` for one cycle in the next cycle, with `result` equal to the selected register.
- R4: With `is_signed`=1 both operands are treated as two's complement and the 64-bit product is signed. With `is_signed`=0 both are zero-extended.
- R5: `busy` rises in the cycle after a multiply is accepted and stays high for exactly 33 cycles: 32 iteration steps plus one sign fix-up cycle.
- R6: In Hi/Lo mode, a read issued while `busy` is high is held. `result_valid` stays low while `busy` is high. The read is answered in the cycle after `busy` falls, with the newly written half. Only one read is held; further reads during the same multiply are ignored.
- R7: A read issued in the last busy cycle returns the half of the product being completed in that cycle, not the older Hi/Lo value.
- R8: A multiply `start` while `busy` is high is ignored. It changes neither the running operation, its length, nor the final Hi/Lo contents.
- R9: In direct mode (`USE_HILO`=0), opcode 3 returns product bits 31:0 and opcode 4 returns bits 63:32. `result_valid` pulses for one cycle in the cycle after `busy` falls.
- R10: Opcodes that do not belong to the configured mode (Hi/Lo mode: 3 and 4; direct mode: 0, 1 and 2) and the codes 5 to 7 are ignored: `busy` and `result_valid` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe |
| op | input | 3 | Opcode: 0 multiply to Hi/Lo, 1 read Hi, 2 read Lo, 3 multiply low half, 4 multiply high half |
| is_signed | input | 1 | 1 = two's-complement operands |
| opa | input | W | First operand |
| opb | input | W | Second operand |
| busy | output | 1 | Multiply in flight |
| result | output | W | Returned register-file value |
| result_valid | output | 1 | One-cycle strobe qualifying `result` |

## Verification
Two functions can land in the same cycle: the retirement that writes Hi/Lo, and the service of a read of Hi or Lo. The bench provokes this in two ways. It holds a read issued mid-multiply, and it issues a fresh read in exactly the last busy cycle, 33 edges after acceptance. It judges both cases by comparing `result` with the half of the new product computed in the bench, which always differs from the previous Hi/Lo contents. A multiply restart during the busy window is judged by the busy length and by the Hi/Lo values read back afterwards.

// File: rtl/mulhl_pkg.sv
package mulhl_pkg;

    typedef enum logic [2:0] {
        OPC_MULT_HL  = 3'd0,
        OPC_READ_HI  = 3'd1,
        OPC_READ_LO  = 3'd2,
        OPC_MUL_LOW  = 3'd3,
        OPC_MUL_HIGH = 3'd4
    } opc_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STEP  = 2'd1,
        ST_FIXUP = 2'd2
    } mstate_e;

endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
    import mulhl_pkg::*;
#(
    parameter int STEPS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    output logic busy,
    output logic step_en,
    output logic fix_en
);
    localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;

    mstate_e         state_q, state_d;
    logic [CW-1:0]   cnt_q;
    logic            last_step;

    assign last_step = (cnt_q == CW'(STEPS - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)    state_d = ST_STEP;
            ST_STEP:  if (last_step) state_d = ST_FIXUP;
            ST_FIXUP:                state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // state register and step counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept && state_q == ST_IDLE)
                cnt_q <= '0;
            else if (state_q == ST_STEP)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs decoded from the state
    always_comb begin
        busy    = 1'b0;
        step_en = 1'b0;
        fix_en  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_STEP:  begin busy = 1'b1; step_en = 1'b1; end
            ST_FIXUP: begin busy = 1'b1; fix_en  = 1'b1; end
            default:  ;
        endcase
    end

endmodule

// File: rtl/mul_core.sv
module mul_core #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step_en,
    input  logic           is_signed,
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    output logic [2*W-1:0] product
);
    localparam int PW = 2 * W;

    logic [PW-1:0] mcand_q;
    logic [W-1:0]  mplier_q;
    logic [PW-1:0] acc_q;
    logic          neg_q;
    logic [W-1:0]  mag_a, mag_b;
    logic          a_neg, b_neg;

    assign a_neg = is_signed & opa[W-1];
    assign b_neg = is_signed & opb[W-1];
    assign mag_a = a_neg ? (~opa + 1'b1) : opa;
    assign mag_b = b_neg ? (~opb + 1'b1) : opb;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            acc_q    <= '0;
            neg_q    <= 1'b0;
        end else if (load) begin
            mcand_q  <= {{W{1'b0}}, mag_a};
            mplier_q <= mag_b;
            acc_q    <= '0;
            neg_q    <= a_neg ^ b_neg;
        end else if (step_en) begin
            if (mplier_q[0])
                acc_q <= acc_q + mcand_q;
            mcand_q  <= mcand_q << 1;
            mplier_q <= mplier_q >> 1;
        end
    end

    assign product = neg_q ? (~acc_q + 1'b1) : acc_q;

endmodule

// File: rtl/mul_retire.sv
module mul_retire #(
    parameter int W        = 32,
    parameter int USE_HILO = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           busy,
    input  logic           fix_en,
    input  logic           accept,
    input  logic           kind_high,
    input  logic           move_req,
    input  logic           move_hi,
    input  logic [2*W-1:0] product,
    output logic [W-1:0]   result,
    output logic           result_valid
);
    localparam bit HILO = (USE_HILO != 0);

    logic [W-1:0] hi_q, lo_q;
    logic         pend_q, pend_hi_q, want_hi_q;
    logic [W-1:0] prod_hi, prod_lo;
    logic         serve_hi;

    assign prod_hi  = product[2*W-1:W];
    assign prod_lo  = product[W-1:0];
    assign serve_hi = pend_q ? pend_hi_q : move_hi;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q         <= '0;
            lo_q         <= '0;
            pend_q       <= 1'b0;
            pend_hi_q    <= 1'b0;
            want_hi_q    <= 1'b0;
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= 1'b0;
            if (accept)
                want_hi_q <= kind_high;
            if (fix_en) begin
                hi_q   <= prod_hi;
                lo_q   <= prod_lo;
                pend_q <= 1'b0;
                if (!HILO) begin
                    result_valid <= 1'b1;
                    result       <= want_hi_q ? prod_hi : prod_lo;
                end else if (pend_q || move_req) begin
                    result_valid <= 1'b1;
                    result       <= serve_hi ? prod_hi : prod_lo;
                end
            end else if (move_req && !busy) begin
                result_valid <= 1'b1;
                result       <= move_hi ? hi_q : lo_q;
            end else if (move_req && busy && !pend_q) begin
                pend_q    <= 1'b1;
                pend_hi_q <= move_hi;
            end
        end
    end

endmodule

// File: rtl/mul_unit.sv
module mul_unit
    import mulhl_pkg::*;
#(
    parameter int W        = 32,
    parameter int USE_HILO = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [2:0]   op,
    input  logic         is_signed,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         busy,
    output logic [W-1:0] result,
    output logic         result_valid
);
    localparam bit HILO  = (USE_HILO != 0);
    localparam int STEPS = W;

    logic           is_mul_op, is_move_op;
    logic           accept, move_req, move_hi, kind_high;
    logic           step_en, fix_en;
    logic [2*W-1:0] product;

    always_comb begin
        if (HILO) begin
            is_mul_op  = (op == OPC_MULT_HL);
            is_move_op = (op == OPC_READ_HI) || (op == OPC_READ_LO);
        end else begin
            is_mul_op  = (op == OPC_MUL_LOW) || (op == OPC_MUL_HIGH);
            is_move_op = 1'b0;
        end
    end

    assign accept    = start & is_mul_op & ~busy;
    assign move_req  = start & is_move_op;
    assign move_hi   = (op == OPC_READ_HI);
    assign kind_high = (op == OPC_MUL_HIGH);

    mul_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .busy    (busy),
        .step_en (step_en),
        .fix_en  (fix_en)
    );

    mul_core #(.W(W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .step_en   (step_en),
        .is_signed (is_signed),
        .opa       (opa),
        .opb       (opb),
        .product   (product)
    );

    mul_retire #(.W(W), .USE_HILO(USE_HILO)) u_retire (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy         (busy),
        .fix_en       (fix_en),
        .accept       (accept),
        .kind_high    (kind_high),
        .move_req     (move_req),
        .move_hi      (move_hi),
        .product      (product),
        .result       (result),
        .result_valid (result_valid)
    );

endmodule

// File: rtl/mul_unit_chk.sv
module mul_unit_chk
    import mulhl_pkg::*;
#(
    parameter int W        = 32,
    parameter int USE_HILO = 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [2:0] op,
    input logic       busy,
    input logic       result_valid
);
    localparam int SPAN = W + 1;
    localparam int RW   = $clog2(SPAN + 1) + 1;

    logic          c_mul, c_move, c_foreign;
    logic [RW-1:0] run_len;

    assign c_mul     = (USE_HILO != 0) ? (op == OPC_MULT_HL)
                                       : (op == OPC_MUL_LOW || op == OPC_MUL_HIGH);
    assign c_move    = (USE_HILO != 0) && (op == OPC_READ_HI || op == OPC_READ_LO);
    assign c_foreign = !c_mul && !c_move;

    always_ff @(posedge clk) begin
        if (!rst_n)      run_len <= '0;
        else if (busy)   run_len <= run_len + 1'b1;
        else             run_len <= '0;
    end

    assert_busy_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && c_mul && !busy) |=> busy);

    assert_busy_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(run_len) == RW'(SPAN - 1)));

    assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len <= RW'(SPAN - 1)));

    assert_quiet_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !result_valid);

    assert_foreign_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && c_foreign && !busy) |=> (!busy && !result_valid));

    generate
        if (USE_HILO != 0) begin : g_hilo
            assert_idle_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (start && c_move && !busy) |=> result_valid);
        end else begin : g_direct
            assert_direct_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(busy) |-> result_valid);
        end
    endgenerate

endmodule

bind mul_unit mul_unit_chk #(.W(W), .USE_HILO(USE_HILO)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .op           (op),
    .busy         (busy),
    .result_valid (result_valid)
);

// File: tb/tb_mul_unit.sv
module tb_mul_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic        is_signed = 1'b0;
    logic [31:0] opa = '0, opb = '0;
    logic        busy, busy3;
    logic [31:0] result, result3;
    logic        result_valid, result_valid3;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    mul_unit #(.W(32), .USE_HILO(1)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .is_signed(is_signed),
        .opa(opa), .opb(opb), .busy(busy), .result(result), .result_valid(result_valid)
    );

    mul_unit #(.W(32), .USE_HILO(0)) dut3 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .is_signed(is_signed),
        .opa(opa), .opb(opb), .busy(busy3), .result(result3), .result_valid(result_valid3)
    );

    function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b,
                                             input logic sg);
        logic signed [63:0] sa, sb;
        if (sg) begin
            sa = $signed({{32{a[31]}}, a});
            sb = $signed({{32{b[31]}}, b});
            return 64'(sa * sb);
        end
        return {32'b0, a} * {32'b0, b};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive a one-cycle request; returns at the negedge after the accepting edge
    task automatic issue(input logic [2:0] o, input logic sg, input logic [31:0] a,
                         input logic [31:0] b);
        op = o; is_signed = sg; opa = a; opb = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic read_hl(input logic hi_sel, input logic [31:0] exp, input string req);
        issue(hi_sel ? 3'd1 : 3'd2, 1'b0, '0, '0);
        chk({req, " read valid"}, 64'(result_valid), 64'd1);
        chk({req, " read value"}, 64'(result), 64'(exp));
    endtask

    task automatic t_reset;
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 valid", 64'(result_valid), 64'd0);
        chk("R1 result", 64'(result), 64'd0);
        read_hl(1'b1, 32'd0, "R1 hi");
        read_hl(1'b0, 32'd0, "R1 lo");
    endtask

    task automatic t_hilo(input logic [31:0] a, input logic [31:0] b, input logic sg);
        logic [63:0] p;
        p = ref_prod(a, b, sg);
        issue(3'd0, sg, a, b);
        chk("R5 busy rises", 64'(busy), 64'd1);
        chk("R10 direct unit ignores op 0", 64'(busy3), 64'd0);
        repeat (32) @(negedge clk);
        chk("R5 busy in last cycle", 64'(busy), 64'd1);
        @(negedge clk);
        chk("R5 busy falls", 64'(busy), 64'd0);
        chk("R2 no valid from multiply", 64'(result_valid), 64'd0);
        read_hl(1'b0, p[31:0], sg ? "R4 lo" : "R2 lo");
        @(negedge clk);
        chk("R3 one-cycle pulse", 64'(result_valid), 64'd0);
        read_hl(1'b1, p[63:32], sg ? "R4 hi" : "R2 hi");
    endtask

    task automatic t_move_wait;
        logic [63:0] p;
        int leaked;
        leaked = 0;
        p = ref_prod(32'hDEAD_BEEF, 32'h0000_1357, 1'b0);
        issue(3'd0, 1'b0, 32'hDEAD_BEEF, 32'h0000_1357);
        repeat (4) @(negedge clk);
        issue(3'd1, 1'b0, '0, '0);
        issue(3'd2, 1'b0, '0, '0);
        for (int i = 0; i < 60 && busy; i++) begin
            if (result_valid) leaked++;
            @(negedge clk);
        end
        chk("R6 no valid while busy", 64'(leaked), 64'd0);
        chk("R6 held read answered", 64'(result_valid), 64'd1);
        chk("R6 held read value is new hi", 64'(result), 64'(p[63:32]));
        @(negedge clk);
        chk("R6 second held read ignored", 64'(result_valid), 64'd0);
    endtask

    task automatic t_last_cycle;
        logic [63:0] p;
        p = ref_prod(32'h0F0F_1234, 32'h0000_0077, 1'b0);
        issue(3'd0, 1'b0, 32'h0F0F_1234, 32'h0000_0077);
        repeat (32) @(negedge clk);
        chk("R7 still busy", 64'(busy), 64'd1);
        issue(3'd2, 1'b0, '0, '0);
        chk("R7 valid", 64'(result_valid), 64'd1);
        chk("R7 new lo", 64'(result), 64'(p[31:0]));
        chk("R7 busy done", 64'(busy), 64'd0);
    endtask

    task automatic t_restart;
        logic [63:0] p;
        p = ref_prod(32'h0000_00AB, 32'h0000_0CDE, 1'b0);
        issue(3'd0, 1'b0, 32'h0000_00AB, 32'h0000_0CDE);
        repeat (3) @(negedge clk);
        issue(3'd0, 1'b1, 32'h7777_7777, 32'h9999_9999);
        repeat (28) @(negedge clk);
        chk("R8 busy unchanged", 64'(busy), 64'd1);
        @(negedge clk);
        chk("R8 busy ends on time", 64'(busy), 64'd0);
        read_hl(1'b1, p[63:32], "R8 hi");
        read_hl(1'b0, p[31:0], "R8 lo");
    endtask

    task automatic t_direct(input logic [31:0] a, input logic [31:0] b, input logic sg,
                            input logic high);
        logic [63:0] p;
        p = ref_prod(a, b, sg);
        issue(high ? 3'd4 : 3'd3, sg, a, b);
        chk("R10 hilo unit ignores op 3/4 busy", 64'(busy), 64'd0);
        chk("R10 hilo unit ignores op 3/4 valid", 64'(result_valid), 64'd0);
        chk("R9 busy rises", 64'(busy3), 64'd1);
        repeat (32) @(negedge clk);
        chk("R9 no early valid", 64'(result_valid3), 64'd0);
        @(negedge clk);
        chk("R9 valid", 64'(result_valid3), 64'd1);
        chk("R9 value", 64'(result3), high ? 64'(p[63:32]) : 64'(p[31:0]));
        @(negedge clk);
        chk("R9 pulse", 64'(result_valid3), 64'd0);
    endtask

    task automatic t_foreign;
        issue(3'd1, 1'b0, '0, '0);
        chk("R10 direct ignores read", 64'(result_valid3), 64'd0);
        chk("R10 direct stays idle", 64'(busy3), 64'd0);
        issue(3'd6, 1'b0, 32'd3, 32'd3);
        chk("R10 code 6 busy", 64'(busy), 64'd0);
        chk("R10 code 6 valid", 64'(result_valid), 64'd0);
        chk("R10 code 6 direct", 64'(busy3), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hilo(32'd7, 32'd9, 1'b0);
        t_hilo(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        t_hilo(32'h1234_5678, 32'h9ABC_DEF0, 1'b0);
        t_hilo(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
        t_hilo(32'h8000_0000, 32'h8000_0000, 1'b1);
        t_hilo(32'hFFFF_FFFD, 32'd5, 1'b1);
        t_hilo(32'h0000_0000, 32'h8765_4321, 1'b1);
        t_move_wait();
        t_last_cycle();
        t_restart();
        t_direct(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 1'b0);
        t_direct(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 1'b1);
        t_direct(32'h8000_0000, 32'h0000_0003, 1'b1, 1'b1);
        t_direct(32'hFFFF_FFF9, 32'h0000_0006, 1'b1, 1'b0);
        t_foreign();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule